// File: doc/BRIEF.md
# GPIO Data Register Bank

A 32-pin general-purpose I/O data block behind a small memory-mapped register interface. Software reaches it through a word address, a write strobe, 32 bits of write data and 32 bits of registered read data. Inside there is an output value register, a direction register and a two-stage synchronized copy of the pin levels. Each pin is driven from the matching output register bit, and its output enable comes from the matching direction bit.

Three write-only alias words change the output register without a read-modify-write sequence. One alias sets the output bits that are marked in the write data. One clears them, and one inverts them. The pin-level word returns a per-bit blend. A pin whose direction bit is 1 returns its output register bit. A pin whose direction bit is 0 returns its synchronized input. A single read therefore gives the level that each pin currently has.

Pin multiplexing, pulls, input filtering and interrupts are not part of this block. Every access is a full 32-bit word.

Top module: `gpio_data_bank`

## Requirements
- R1: Word address 0 is the output register. A write loads `wr_data` into it and a read returns it. `pin_out` equals this register from the clock edge that performed the write.
- R2: A write to word address 1 sets each output bit whose `wr_data` bit is 1. All other output bits keep their values.
- R3: A write to word address 2 clears each output bit whose `wr_data` bit is 1. All other output bits keep their values.
- R4: A write to word address 3 inverts each output bit whose `wr_data` bit is 1. Two identical toggle writes restore the original value.
- R5: Reads of word addresses 1, 2, 3, 6 and 7 return zero. Writes to word addresses 6 and 7 change neither the output register nor the direction register.
- R6: A read of word address 4 returns, for each bit n, the output register bit n when direction bit n is 1, and synchronized pin input n when direction bit n is 0. Writes to word address 4 are ignored.
- R7: Word address 5 is the direction register and can be both read and written. Bit value 1 means output and 0 means input. `pin_oe` equals this register.
- R8: Pin inputs pass through two flip-flops. A change on `pin_in` therefore first shows in `rd_data` for word address 4 on the third rising edge after the change. It does not show on the second.
- R9: Synchronous active-high reset clears the output register, the direction register, the synchronizer stages and `rd_data`. All pins therefore start as inputs, with `pin_out` driving 0.
- R10: `rd_data` is registered. It shows the value of the word selected by `addr` at the previous rising edge, taken before any write on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Word address of the access |
| wr_en | input | 1 | Write strobe for the addressed word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data of the addressed word |
| pin_in | input | 32 | Pin levels, asynchronous to clk |
| pin_out | output | 32 | Output value for each pin |
| pin_oe | output | 32 | Output enable for each pin (1 = drive) |

## Verification
The latency property compares `rd_data` with `pin_in` from three edges earlier. It is armed only once three edges have passed since reset. It also assumes that `pin_in` changes only between clock edges, so that each stage captures a settled value. The stimulus meets this by changing `pin_in` and every bus input on the falling edge only. All other properties assume no more than one register write per edge. This always holds, because the bus carries a single address.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    WSEL_OUT = 3'd0,
    WSEL_SET = 3'd1,
    WSEL_CLR = 3'd2,
    WSEL_TGL = 3'd3,
    WSEL_PIN = 3'd4,
    WSEL_DIR = 3'd5
  } wsel_e;

  function automatic logic is_sel(input logic [ADDR_W-1:0] a, input wsel_e s);
    return a == s;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[LAST];

endmodule

// File: rtl/gpio_out_ctl.sv
module gpio_out_ctl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  out_q
);

  logic [WIDTH-1:0] out_d;
  logic             ld_all, do_set, do_clr, do_tgl;

  always_comb begin
    ld_all = wr_en && is_sel(addr, WSEL_OUT);
    do_set = wr_en && is_sel(addr, WSEL_SET);
    do_clr = wr_en && is_sel(addr, WSEL_CLR);
    do_tgl = wr_en && is_sel(addr, WSEL_TGL);
  end

  // Per-bit next state: the alias words touch only the marked bits.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      out_d[b] = out_q[b];
      if (ld_all)                  out_d[b] = wr_data[b];
      else if (do_set && wr_data[b]) out_d[b] = 1'b1;
      else if (do_clr && wr_data[b]) out_d[b] = 1'b0;
      else if (do_tgl && wr_data[b]) out_d[b] = ~out_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= out_d;
  end

endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  dir_q
);

  always_ff @(posedge clk) begin
    if (rst)                                 dir_q <= '0;
    else if (wr_en && is_sel(addr, WSEL_DIR)) dir_q <= wr_data;
  end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  out_q,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rd_q
);

  logic [WIDTH-1:0] level_view;
  logic [WIDTH-1:0] rd_d;

  // Driven pins report what is driven, the others report the sampled level.
  for (genvar b = 0; b < WIDTH; b++) begin : g_view
    assign level_view[b] = dir_q[b] ? out_q[b] : pin_sync[b];
  end

  always_comb begin
    unique case (addr)
      WSEL_OUT: rd_d = out_q;
      WSEL_PIN: rd_d = level_view;
      WSEL_DIR: rd_d = dir_q;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

endmodule

// File: rtl/gpio_data_bank.sv
module gpio_data_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);

  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] pin_sync;

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_out_ctl #(.WIDTH(NPINS)) u_out (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .out_q   (out_q)
  );

  gpio_dir_reg #(.WIDTH(NPINS)) u_dir (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .dir_q   (dir_q)
  );

  gpio_rd_mux #(.WIDTH(NPINS)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .out_q    (out_q),
    .dir_q    (dir_q),
    .pin_sync (pin_sync),
    .rd_q     (rd_data)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_data_bank_chk.sv
module gpio_data_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [NPINS-1:0]  wr_data,
  input logic [NPINS-1:0]  rd_data,
  input logic [NPINS-1:0]  pin_in,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe
);

  logic [1:0] since_rst = 2'd0;
  logic       was_rst   = 1'b0;

  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  // R9: the edge after a reset cycle leaves everything cleared
  always_ff @(posedge clk) begin
    if (was_rst) begin
      a_r9_reset_clear: assert (pin_out == '0 && pin_oe == '0 && rd_data == '0)
        else $error("a_r9_reset_clear");
    end
  end

  a_r1_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == WSEL_OUT) |=> pin_out == $past(wr_data));

  a_r2_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == WSEL_SET) |=> pin_out == ($past(pin_out) | $past(wr_data)));

  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == WSEL_CLR) |=> pin_out == ($past(pin_out) & ~$past(wr_data)));

  a_r4_toggle: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == WSEL_TGL) |=> pin_out == ($past(pin_out) ^ $past(wr_data)));

  a_r5_alias_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == WSEL_SET || addr == WSEL_CLR || addr == WSEL_TGL || addr > WSEL_DIR)
      |=> rd_data == '0);

  a_r5_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || addr >= WSEL_PIN) |=> $stable(pin_out));

  a_r7_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == WSEL_DIR) |=> $stable(pin_oe));

  a_r7_dir_read: assert property (@(posedge clk) disable iff (rst)
    (addr == WSEL_DIR) |=> rd_data == $past(pin_oe));

  a_r8_level_view: assert property (@(posedge clk) disable iff (rst)
    (addr == WSEL_PIN && since_rst == 3) |=>
      rd_data == (($past(pin_oe) & $past(pin_out)) | (~$past(pin_oe) & $past(pin_in, 3))));

endmodule

bind gpio_data_bank gpio_data_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .pin_in  (pin_in),
  .pin_out (pin_out),
  .pin_oe  (pin_oe)
);

// File: tb/test_gpio_data_bank.sv
module test_gpio_data_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;
  localparam logic [31:0] PIN_PAT = 32'hA5A5_0F0F;

  // entry: {is_write, addr, data, expected read}
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 3'd0, 32'h1234_5678, 32'h0},            // R1 load
    {1'b0, 3'd0, 32'h0, 32'h1234_5678},            // R1 read back
    {1'b1, 3'd1, 32'h0000_FFFF, 32'h0},            // R2 set
    {1'b0, 3'd0, 32'h0, 32'h1234_FFFF},
    {1'b1, 3'd2, 32'hFF00_00F0, 32'h0},            // R3 clear
    {1'b0, 3'd0, 32'h0, 32'h0034_FF0F},
    {1'b1, 3'd3, 32'h0F0F_0F0F, 32'h0},            // R4 toggle
    {1'b0, 3'd0, 32'h0, 32'h0F3B_F000},
    {1'b0, 3'd1, 32'h0, 32'h0},                    // R5 alias reads
    {1'b0, 3'd2, 32'h0, 32'h0},
    {1'b0, 3'd3, 32'h0, 32'h0},
    {1'b1, 3'd5, 32'hFFFF_0000, 32'h0},            // R7 direction
    {1'b0, 3'd5, 32'h0, 32'hFFFF_0000},
    {1'b0, 3'd4, 32'h0, 32'h0F3B_0F0F},            // R6 blend
    {1'b1, 3'd4, 32'hFFFF_FFFF, 32'h0},            // R6 write ignored
    {1'b0, 3'd4, 32'h0, 32'h0F3B_0F0F},
    {1'b0, 3'd0, 32'h0, 32'h0F3B_F000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_data_bank i_gpio_data_bank (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 pin_out after reset", pin_out, 32'h0);
    check("R9 pin_oe after reset", pin_oe, 32'h0);
    check("R9 rd_data after reset", rd_data, 32'h0);

    pin_in = PIN_PAT;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][67]) wr(VEC[i][66:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][66:64], v);
        check($sformatf("R1-table vector %0d", i), v, VEC[i][31:0]);
      end
    end
    check("R1 pin_out follows output register", pin_out, 32'h0F3B_F000);
    check("R7 pin_oe follows direction", pin_oe, 32'hFFFF_0000);

    // R4: a second identical toggle restores the value
    wr(3'd3, 32'h8000_0001);
    wr(3'd3, 32'h8000_0001);
    check("R4 double toggle", pin_out, 32'h0F3B_F000);

    // R2 / R3: zero masks change nothing
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0);
    check("R2 R3 zero mask", pin_out, 32'h0F3B_F000);

    // R5: unused words read zero and writes there are ignored
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, v); check("R5 word 6 reads zero", v, 32'h0);
    rd(3'd7, v); check("R5 word 7 reads zero", v, 32'h0);
    check("R5 output untouched", pin_out, 32'h0F3B_F000);
    check("R5 direction untouched", pin_oe, 32'hFFFF_0000);

    // R10: read on the edge of a write returns the old value
    @(negedge clk);
    addr = 3'd0; wr_data = 32'hDEAD_BEEF; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 read before same-edge write", rd_data, 32'h0F3B_F000);
    @(negedge clk);
    check("R10 new value next edge", rd_data, 32'hDEAD_BEEF);

    // R8: synchronizer latency, all pins inputs
    wr(3'd5, 32'h0);
    rd(3'd4, v);
    check("R8 settled input", v, PIN_PAT);
    @(negedge clk);
    pin_in = 32'h0000_0001;
    @(negedge clk);
    @(negedge clk);
    check("R8 not visible after two edges", rd_data, PIN_PAT);
    @(negedge clk);
    check("R8 visible after three edges", rd_data, 32'h0000_0001);

    // R9: reset in the middle of operation
    wr(3'd5, 32'h0000_00FF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 mid-run reset output", pin_out, 32'h0);
    check("R9 mid-run reset direction", pin_oe, 32'h0);
    rd(3'd5, v);
    check("R9 direction reads zero", v, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule